// File: doc/BRIEF.md
# Microcoded Datapath Sequencer Core

This block is a small processing core that runs callable DSP routines stored as 28-bit microinstructions in an internal ROM. A caller pulses a call strobe together with an 11-bit entry address. The core then fetches, decodes and executes one microinstruction per clock until it reaches an end word or a jump to itself, and returns to idle. Each instruction reads two operands, combines them in a 24-bit ALU, and may write the result back to a 32-entry register file, present it on the result port, or redirect the program counter.

The A operand is either a register or the 8-bit input byte placed into one of three byte lanes. The B operand is either a register or a 12-bit literal carried in the instruction. Two consecutive instructions can together build a full 24-bit constant: the first one stages its literal, and the second one supplies the upper half. A jump whose literal bit 11 is set is conditional on a nonzero ALU result. The ROM contents are a parameter array, so each instance carries its own program.

The sequencer has two states. IDLE waits for a call. RUN executes the instructions. The transitions are CALL (IDLE or RUN to RUN, which loads the PC), STEP (RUN to RUN, PC plus one), JUMP (RUN to RUN, PC takes the target), END (RUN to IDLE on the all-ones word) and PARK (RUN to IDLE on a taken jump whose target is the PC of that jump).

Top module: `useq_core`

## Requirements
- R1: After reset the core is in IDLE with PC 0, out_valid_o low and out_data_o zero, and all 32 registers read as zero. While idle and without a call, out_valid_o stays low.
- R2: A call_i high at a clock edge loads the PC with entry_i and enters RUN. The instruction at that address executes in the following cycle. If that instruction has its output enable set, out_valid_o is high in the cycle after that.
- R3: The instruction bits, from MSB to LSB, are: [27:24] ALU function, [23] output enable, [22] active-low write enable, [21] jump, [20] stage literal, [19:18] A source, [17:13] A address, [12] B source, [11:0] literal, where [11:7] is also the B address. For the A source, 00 selects register A. Codes 01, 10 and 11 place in_byte_i at bits 23:16, 15:8 and 7:0 respectively, with zeros elsewhere.
- R4: When bit 22 is 0, the ALU result is written to the register named by the A address, whatever the A source is. When bit 22 is 1, no register changes.
- R5: A B source of 0 selects the register at the B address. A B source of 1 selects the literal zero-extended to 24 bits. When the previous executed instruction had its stage bit set, it instead selects {current literal, staged literal}.
- R6: ALU function codes are: 0 set multiply scale (result B), 1 A, 2 B, 3 A+B, 4 A-B, 5 scaled signed multiply, 6 arithmetic right shift of A by B (saturating at 23), 7 A==B, 8 signed A<B, 9 signed A>B, 10 A!=B, 11 AND, 12 NOT A, 13 XOR, 14 OR, 15 clip A to the range -B..B. Comparisons return 1 or 0.
- R7: A jump with literal bit 11 clear is always taken, and the next PC is literal[10:0].
- R8: A jump with literal bit 11 set is taken only when the ALU result of that same instruction is nonzero. Otherwise the PC steps by one, and a non-jump instruction steps by one as well.
- R9: An executed instruction with output enable set registers the ALU result on out_data_o and raises out_valid_o for the next cycle. In all other cycles out_valid_o is low and out_data_o holds its value.
- R10: The all-ones word ends the routine without side effects and returns to IDLE. A taken jump to its own address executes its other effects and then returns to IDLE.
- R11: A call that arrives while running preempts the instruction of that cycle, which has no effect, and discards any staged literal.
- R12: Addresses at or above the ROM depth read as the all-ones end word.
- R13: Function 0 stores min(B,23) as the multiply scale. Function 5 returns the signed 48-bit product A*B arithmetically shifted right by the scale, truncated to 24 bits. The scale resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Call strobe, sampled at each rising edge |
| entry_i | input | 11 | Entry address of the called routine |
| in_byte_i | input | 8 | Input data byte for the A-source byte lanes |
| out_valid_o | output | 1 | Result valid, one cycle per output-enabled instruction |
| out_data_o | output | 24 | Registered ALU result |

## Verification
The bound checker verifies the following on every cycle: a call loads the PC with the entry address and enters RUN; a call, or an idle cycle, is followed by no valid pulse; the result port holds whenever valid is low; an end word parks the core with the PC unchanged; and a non-jump instruction advances the PC by one. Several behaviours can only be shown by the bench's reference model over whole routines. These are the ALU arithmetic and scaling, byte-lane placement, register write-back, two-instruction constant building, loop exit through a conditional jump, forward jumps skipping instructions, preemption of a staged literal, and reads beyond the ROM depth.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int WORD_W = 28;
    localparam int DATA_W = 24;
    localparam int PC_W   = 11;
    localparam int LIT_W  = 12;
    localparam int RADR_W = 5;

    typedef enum logic [3:0] {
        FN_SCALE = 4'h0, FN_PASSA = 4'h1, FN_PASSB = 4'h2, FN_ADD = 4'h3,
        FN_SUB   = 4'h4, FN_MUL   = 4'h5, FN_SHR   = 4'h6, FN_EQ  = 4'h7,
        FN_LT    = 4'h8, FN_GT    = 4'h9, FN_NE    = 4'hA, FN_AND = 4'hB,
        FN_INV   = 4'hC, FN_XOR   = 4'hD, FN_OR    = 4'hE, FN_CLIP = 4'hF
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRC_REG = 2'b00, SRC_LANE_HI = 2'b01, SRC_LANE_MID = 2'b10, SRC_LANE_LO = 2'b11
    } a_src_e;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_e;

    typedef struct packed {
        logic [3:0]        fn;
        logic              oe;
        logic              we_n;
        logic              jmp;
        logic              stage;
        logic [1:0]        a_src;
        logic [RADR_W-1:0] a_addr;
        logic              b_lit;
        logic [LIT_W-1:0]  lit;
    } uword_t;

    localparam logic [WORD_W-1:0] END_WORD = '1;

    function automatic logic [WORD_W-1:0] uw(
        input logic [3:0] fn, input logic oe, input logic we_n, input logic jmp,
        input logic stage, input logic [1:0] a_src, input logic [RADR_W-1:0] a_addr,
        input logic b_lit, input logic [LIT_W-1:0] lit);
        return {fn, oe, we_n, jmp, stage, a_src, a_addr, b_lit, lit};
    endfunction
endpackage

// File: rtl/useq_alu.sv
module useq_alu #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec,
    input  logic [3:0]    fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res
);
    import useq_pkg::*;

    localparam int SHW = $clog2(DW);
    localparam logic [DW-1:0] B_LIM = DW'(DW - 1);

    logic [SHW-1:0]       scale_q;
    logic [SHW-1:0]       b_amt;
    logic signed [DW-1:0] sa, sb, neg_b;
    logic signed [2*DW-1:0] prod;

    assign sa    = a;
    assign sb    = b;
    assign neg_b = -sb;
    assign b_amt = (b > B_LIM) ? SHW'(DW - 1) : b[SHW-1:0];
    assign prod  = (2*DW)'(sa) * (2*DW)'(sb);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_q <= '0;
        end else if (exec && alu_fn_e'(fn) == FN_SCALE) begin
            scale_q <= b_amt;
        end
    end

    always_comb begin
        res = '0;
        unique case (alu_fn_e'(fn))
            FN_SCALE: res = b;
            FN_PASSA: res = a;
            FN_PASSB: res = b;
            FN_ADD:   res = a + b;
            FN_SUB:   res = a - b;
            FN_MUL:   res = DW'(prod >>> scale_q);
            FN_SHR:   res = DW'(sa >>> b_amt);
            FN_EQ:    res = {{(DW-1){1'b0}}, (a == b)};
            FN_LT:    res = {{(DW-1){1'b0}}, (sa < sb)};
            FN_GT:    res = {{(DW-1){1'b0}}, (sa > sb)};
            FN_NE:    res = {{(DW-1){1'b0}}, (a != b)};
            FN_AND:   res = a & b;
            FN_INV:   res = ~a;
            FN_XOR:   res = a ^ b;
            FN_OR:    res = a | b;
            FN_CLIP: begin
                if (sa > sb)         res = b;
                else if (sa < neg_b) res = neg_b;
                else                 res = a;
            end
        endcase
    end
endmodule

// File: rtl/useq_rf.sv
module useq_rf #(
    parameter int DW    = 24,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign hit[i] = we && (waddr == AW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i]) mem[i] <= wdata;
            end
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/useq_rom.sv
module useq_rom #(
    parameter int WW    = 28,
    parameter int AW    = 11,
    parameter int DEPTH = 32,
    parameter logic [WW-1:0] INIT [DEPTH] = '{default: '1}
) (
    input  logic [AW-1:0] addr,
    output logic [WW-1:0] word
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic in_range;
    assign in_range = int'(addr) < DEPTH;
    assign word     = in_range ? INIT[addr[IW-1:0]] : '1;
endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int ROM_DEPTH = 32,
    parameter logic [WORD_W-1:0] ROM_INIT [ROM_DEPTH] = '{
        0: uw(FN_PASSA, 1'b0, 1'b0, 1'b0, 1'b0, SRC_LANE_LO, 5'd1, 1'b0, 12'd0),
        1: uw(FN_ADD,   1'b1, 1'b0, 1'b0, 1'b0, SRC_REG,     5'd1, 1'b0, {5'd1, 7'd0}),
        default: END_WORD
    }
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              call_i,
    input  logic [PC_W-1:0]   entry_i,
    input  logic [7:0]        in_byte_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o
);
    seq_state_e        state_q, state_d;
    logic [PC_W-1:0]   pc_q, pc_d;
    logic [WORD_W-1:0] rom_word;
    uword_t            iw;
    logic              running, is_end, exec;
    logic [LIT_W-1:0]  stage_q;
    logic              stage_vld_q;
    logic [DATA_W-1:0] reg_a, reg_b, opa, opb, alu_res;
    logic              jump_taken;
    logic [PC_W-1:0]   target;

    useq_rom #(.WW(WORD_W), .AW(PC_W), .DEPTH(ROM_DEPTH), .INIT(ROM_INIT)) u_rom (
        .addr(pc_q), .word(rom_word)
    );

    assign iw      = uword_t'(rom_word);
    assign running = (state_q == ST_RUN);
    assign is_end  = (rom_word == END_WORD);
    assign exec    = running && !call_i && !is_end;

    useq_rf #(.DW(DATA_W), .DEPTH(32)) u_rf (
        .clk(clk_i), .rst_n(rst_ni),
        .we(exec && !iw.we_n), .waddr(iw.a_addr), .wdata(alu_res),
        .raddr_a(iw.a_addr), .raddr_b(iw.lit[LIT_W-1 -: RADR_W]),
        .rdata_a(reg_a), .rdata_b(reg_b)
    );

    always_comb begin
        unique case (a_src_e'(iw.a_src))
            SRC_REG:      opa = reg_a;
            SRC_LANE_HI:  opa = {in_byte_i, 16'h0000};
            SRC_LANE_MID: opa = {8'h00, in_byte_i, 8'h00};
            SRC_LANE_LO:  opa = {16'h0000, in_byte_i};
        endcase
    end

    always_comb begin
        if (!iw.b_lit)        opb = reg_b;
        else if (stage_vld_q) opb = {iw.lit, stage_q};
        else                  opb = {{(DATA_W-LIT_W){1'b0}}, iw.lit};
    end

    useq_alu #(.DW(DATA_W)) u_alu (
        .clk(clk_i), .rst_n(rst_ni), .exec(exec),
        .fn(iw.fn), .a(opa), .b(opb), .res(alu_res)
    );

    assign target     = iw.lit[PC_W-1:0];
    assign jump_taken = iw.jmp && (!iw.lit[LIT_W-1] || (alu_res != '0));

    // next-state: CALL, STEP, JUMP, END, PARK
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_IDLE: begin
                if (call_i) begin
                    state_d = ST_RUN;
                    pc_d    = entry_i;
                end
            end
            ST_RUN: begin
                if (call_i) begin
                    pc_d = entry_i;
                end else if (is_end) begin
                    state_d = ST_IDLE;
                end else if (jump_taken) begin
                    if (target == pc_q) state_d = ST_IDLE;
                    else                pc_d    = target;
                end else begin
                    pc_d = pc_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
            stage_q     <= '0;
            stage_vld_q <= 1'b0;
        end else begin
            out_valid_o <= exec && iw.oe;
            if (exec && iw.oe) out_data_o <= alu_res;
            stage_vld_q <= exec && iw.stage;
            if (exec && iw.stage) stage_q <= iw.lit;
        end
    end
endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
    parameter int PC_W = 11,
    parameter int DW   = 24,
    parameter int WW   = 28
) (
    input logic            clk,
    input logic            rst_n,
    input logic            call,
    input logic [PC_W-1:0] entry,
    input logic            valid,
    input logic [DW-1:0]   data,
    input logic            running,
    input logic [PC_W-1:0] pc,
    input logic [WW-1:0]   word
);
    a_r2_call_loads_pc: assert property (@(posedge clk) disable iff (!rst_n)
        call |=> (running && pc == $past(entry)));

    a_r11_call_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        call |=> !valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !call) |=> !valid);

    a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(data));

    a_r10_end_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !call && word == '1) |=> (!running && $stable(pc)));

    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !call && word != '1 && !word[21]) |=> (running && pc == PC_W'($past(pc) + 1'b1)));
endmodule

bind useq_core useq_core_chk #(.PC_W(useq_pkg::PC_W), .DW(useq_pkg::DATA_W), .WW(useq_pkg::WORD_W)) u_chk (
    .clk(clk_i), .rst_n(rst_ni), .call(call_i), .entry(entry_i),
    .valid(out_valid_o), .data(out_data_o), .running(running),
    .pc(pc_q), .word(rom_word)
);

// File: tb/useq_core_tb.sv
`timescale 1ns/1ps
module useq_core_tb_top;
    function automatic logic [27:0] enc(int fn, bit oe, bit wen, bit jmp, bit sv,
                                        int asrc, int aaddr, bit bl, int lit);
        return {4'(fn), oe, wen, jmp, sv, 2'(asrc), 5'(aaddr), bl, 12'(lit)};
    endfunction

    localparam logic [27:0] PROG [32] = '{
        0:  enc(1, 0, 0, 0, 0, 1, 1, 0, 0),
        1:  enc(1, 0, 0, 0, 0, 3, 2, 0, 0),
        2:  enc(3, 1, 0, 0, 0, 0, 1, 0, 2 << 7),
        4:  enc(2, 0, 1, 0, 1, 0, 0, 1, 'hABC),
        5:  enc(2, 1, 0, 0, 0, 0, 3, 1, 'h123),
        6:  enc(0, 1, 1, 0, 0, 0, 0, 1, 4),
        7:  enc(5, 1, 0, 0, 0, 0, 3, 1, 'h010),
        9:  enc(2, 0, 0, 0, 0, 0, 4, 1, 3),
        10: enc(4, 1, 0, 0, 0, 0, 4, 1, 1),
        11: enc(1, 0, 1, 1, 0, 0, 4, 0, 'h80A),
        12: enc(15, 1, 0, 0, 0, 1, 5, 1, 'h100),
        13: enc(6, 1, 0, 0, 0, 0, 5, 1, 2),
        14: enc(8, 1, 1, 0, 0, 0, 5, 0, 4 << 7),
        15: enc(12, 1, 0, 0, 0, 0, 5, 0, 0),
        16: enc(1, 1, 1, 1, 0, 0, 5, 0, 16),
        17: enc(11, 1, 1, 0, 0, 3, 0, 1, 'h0F0),
        18: enc(13, 1, 1, 0, 0, 3, 0, 1, 'hFFF),
        19: enc(14, 1, 1, 0, 0, 2, 0, 0, 2 << 7),
        20: enc(7, 1, 1, 0, 0, 0, 4, 0, 4 << 7),
        21: enc(9, 1, 1, 0, 0, 3, 0, 0, 0),
        22: enc(10, 1, 1, 0, 0, 0, 1, 0, 2 << 7),
        24: enc(1, 0, 1, 1, 0, 0, 0, 0, 26),
        25: enc(2, 1, 1, 0, 0, 0, 0, 1, 'h777),
        26: enc(2, 1, 1, 0, 0, 0, 0, 1, 'h555),
        28: enc(5, 1, 0, 0, 0, 1, 6, 1, 3),
        default: 28'hFFFFFFF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call = 1'b0;
    logic [10:0] entry = '0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic [23:0] out_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #5 clk = ~clk;

    useq_core #(.ROM_DEPTH(32), .ROM_INIT(PROG)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .call_i(call), .entry_i(entry),
        .in_byte_i(in_byte), .out_valid_o(out_valid), .out_data_o(out_data)
    );

    // behavioural reference model
    bit          m_run;
    int          m_pc;
    logic [23:0] m_rf [32];
    int          m_scale;
    logic [11:0] m_hold;
    bit          m_pend;
    bit          m_val;
    logic [23:0] m_out;

    function automatic logic [23:0] ref_alu(int fn, logic [23:0] a, logic [23:0] b, int scale);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        int sh = (b > 24'd23) ? 23 : int'(b);
        case (fn)
            0, 2: return b;
            1:  return a;
            3:  return a + b;
            4:  return a - b;
            5:  return 24'((sa * sb) >>> scale);
            6:  return 24'(sa >>> sh);
            7:  return (a == b) ? 24'd1 : 24'd0;
            8:  return (sa < sb) ? 24'd1 : 24'd0;
            9:  return (sa > sb) ? 24'd1 : 24'd0;
            10: return (a != b) ? 24'd1 : 24'd0;
            11: return a & b;
            12: return ~a;
            13: return a ^ b;
            14: return a | b;
            default: begin
                if (sa > sb) return b;
                if (sa < -sb) return 24'(-sb);
                return a;
            end
        endcase
    endfunction

    task automatic model_step();
        logic [27:0] w = (m_pc < 32) ? PROG[m_pc] : 28'hFFFFFFF;
        bit ex = m_run && !call && (w != 28'hFFFFFFF);
        int fn = int'(w[27:24]);
        int asrc = int'(w[19:18]);
        int aad = int'(w[17:13]);
        logic [11:0] lit = w[11:0];
        logic [23:0] a, b, r;
        case (asrc)
            0: a = m_rf[aad];
            1: a = {in_byte, 16'h0};
            2: a = {8'h0, in_byte, 8'h0};
            default: a = {16'h0, in_byte};
        endcase
        if (!w[12]) b = m_rf[int'(lit[11:7])];
        else if (m_pend) b = {lit, m_hold};
        else b = {12'h0, lit};
        r = ref_alu(fn, a, b, m_scale);
        m_val = ex && w[23];
        if (ex && w[23]) m_out = r;
        if (ex && !w[22]) m_rf[aad] = r;
        if (ex && fn == 0) m_scale = (b > 24'd23) ? 23 : int'(b);
        m_pend = ex && w[20];
        if (ex && w[20]) m_hold = lit;
        if (call) begin
            m_run = 1; m_pc = int'(entry);
        end else if (m_run) begin
            if (w == 28'hFFFFFFF) m_run = 0;
            else if (w[21] && (!lit[11] || r != 0)) begin
                if (int'(lit[10:0]) == m_pc) m_run = 0;
                else m_pc = int'(lit[10:0]);
            end else m_pc = (m_pc + 1) % 2048;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_pc = 0; m_scale = 0; m_hold = '0; m_pend = 0;
            m_val = 0; m_out = '0;
            for (int i = 0; i < 32; i++) m_rf[i] = '0;
        end else begin
            model_step();
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (out_valid !== m_val) begin
                n_bad++;
                $display("FAIL %s valid: actual %b expected %b at %0t", tag, out_valid, m_val, $time);
            end
            n_cmp++;
            if (out_data !== m_out) begin
                n_bad++;
                $display("FAIL %s data: actual %h expected %h at %0t", tag, out_data, m_out, $time);
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
        in_byte = in_byte * 8'd5 + 8'h3B;
    endtask

    task automatic run(int n);
        repeat (n) cyc();
    endtask

    task automatic do_call(int e);
        @(negedge clk);
        call = 1'b1;
        entry = 11'(e);
        in_byte = in_byte * 8'd5 + 8'h3B;
        @(negedge clk);
        call = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        n_cmp++;
        if (out_valid !== 1'b0 || out_data !== 24'h0) begin
            n_bad++;
            $display("FAIL R1 reset: actual %b/%h expected 0/000000", out_valid, out_data);
        end
        run(5);
        tag = "R3 R4 R2";
        do_call(0); run(6);
        do_call(0); run(6);
        tag = "R5 R13";
        do_call(4); run(7);
        do_call(28); run(3);
        in_byte = 8'hC7;
        do_call(28); run(3);
        tag = "R8 R6 R10";
        do_call(9); run(18);
        do_call(12); run(8);
        tag = "R6";
        do_call(17); run(9);
        in_byte = 8'h80;
        do_call(12); run(8);
        tag = "R7";
        do_call(24); run(5);
        tag = "R12";
        do_call(100); run(4);
        do_call(2047); run(3);
        tag = "R11";
        do_call(9); run(1);
        do_call(0); run(6);
        do_call(4);
        do_call(5); run(4);
        tag = "R9 R1";
        run(6);
        done = 1'b1;
        report();
    end
endmodule